// File: doc/BRIEF.md
# Complementary Gate-Drive Output Stage with Dead-Time

This block sits between a PWM modulator and the gate drivers of three half-bridge legs. For each leg it receives one raw modulator bit and produces a pair of gate outputs, A and B. A is active while the raw bit is 1 and B is active while it is 0. The raw bit may come from an edge-aligned or a center-aligned modulator, and the stage handles both in the same way.

Each leg can insert a programmable dead-time. After a raw transition, the output that is becoming active waits a set number of clock cycles. The output that is becoming passive drops at once, so both switches are never on together. A commutation override can replace the own signals of all six outputs. Each output is then either forced passive or made to follow leg 0's A signal, taken after dead-time insertion. A per-leg polarity mapping then turns active and passive into pin levels. All six pins are registered.

Top module: `pwm_gate_stage`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge every `out_a` bit is 0 and every `out_b` bit is 1, whatever the configuration inputs are.
- R2: With dead-time disabled, override off and `pol_inv` 0, `out_a[c]` equals `raw_pwm[c]` as sampled two clock edges earlier, and `out_b[c]` is its complement.
- R3: With dead-time enabled and a length L > 0 on leg c, a raw transition makes the output that is becoming active go active exactly L cycles later than it would with dead-time off. Both outputs of the leg stay passive in between.
- R4: An output that becomes passive does so with the two-edge latency of R2, independent of the dead-time setting.
- R5: If the raw bit changes again before a pending dead-time has run out, the pending activation is dropped. The other output then waits the full L cycles counted from the newest transition.
- R6: A dead-time length of 0 with dead-time enabled behaves exactly like dead-time disabled.
- R7: `pol_inv[c]` = 1 maps active to low and passive to high on both pins of leg c. With `pol_inv[c]` = 0, active is high.
- R8: When `cp_en` is 1, bit 2c of `cp_pat` controls `out_a[c]` and bit 2c+1 controls `out_b[c]`. A 0 forces that output passive. A 1 makes it follow leg 0's internal A signal after dead-time. The polarity of the output's own leg is applied afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_pwm | input | NUM_CH | Raw modulator bit per leg (1 = A side active) |
| dt_en | input | NUM_CH | Dead-time enable per leg |
| dt_len | input | NUM_CH*DT_W | Dead-time length in cycles, leg c at bits [c*DT_W +: DT_W] |
| pol_inv | input | NUM_CH | Per-leg polarity: 1 = active low |
| cp_en | input | 1 | Commutation override enable |
| cp_pat | input | 2*NUM_CH | Override pattern, bit 2c for A of leg c, bit 2c+1 for B |
| out_a | output | NUM_CH | A gate pin per leg |
| out_b | output | NUM_CH | B gate pin per leg |

## Verification
The hardest situation to reach is a raw bit that reverses while a dead-time count is still running. A pending activation must be dropped and a fresh count started for the opposite output. The same applies when that happens on leg 0 while the override routes leg 0's delayed A signal to other pins. The stimulus gets there by toggling the raw bits at random with gaps shorter than the programmed length, both with the override off and with it on. Configuration changes are applied only after every leg has settled, so each expected value follows from the requirements alone.

// File: rtl/pwm_out_pkg.sv
package pwm_out_pkg;

    localparam int DEF_NUM_CH = 3;
    localparam int DEF_DT_W   = 10;

    // internal active/passive state of one leg (1 = active)
    typedef struct packed {
        logic a;
        logic b;
    } gate_pair_t;

    // selects where a pin's active state comes from
    typedef enum logic [1:0] {
        SRC_OWN     = 2'd0,
        SRC_PASSIVE = 2'd1,
        SRC_LEG0_A  = 2'd2
    } pin_src_e;

    function automatic pin_src_e pick_src(input logic ovr_on, input logic pat_bit);
        if (!ovr_on)
            return SRC_OWN;
        return pat_bit ? SRC_LEG0_A : SRC_PASSIVE;
    endfunction

    function automatic logic resolve(input pin_src_e src, input logic own, input logic leg0_a);
        case (src)
            SRC_OWN:    return own;
            SRC_LEG0_A: return leg0_a;
            default:    return 1'b0;
        endcase
    endfunction

    // active/passive to pin level
    function automatic logic to_level(input logic active, input logic inv);
        return active ^ inv;
    endfunction

endpackage

// File: rtl/pwm_deadtime.sv
module pwm_deadtime
    import pwm_out_pkg::*;
#(
    parameter int DT_W = DEF_DT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            raw,
    input  logic            dt_on,
    input  logic [DT_W-1:0] dt_len,
    output gate_pair_t      act
);

    logic            lvl_q;
    logic [DT_W-1:0] cnt_q;
    logic            use_dt;
    logic            flip;
    logic            settled;

    assign use_dt  = dt_on && (dt_len != '0);
    assign flip    = (raw != lvl_q);
    assign settled = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else if (flip) begin
            lvl_q <= raw;
            cnt_q <= use_dt ? dt_len : '0;
        end else if (!settled) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign act.a = lvl_q & settled;
    assign act.b = ~lvl_q & settled;

    // R3: a delayed transition leaves both sides passive on the next cycle
    p_dt_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (flip && use_dt) |=> (!act.a && !act.b));

    // R4: the side losing activity drops without waiting
    p_fast_off_a_r4: assert property (@(posedge clk) disable iff (rst)
        (lvl_q && !raw) |=> !act.a);
    p_fast_off_b_r4: assert property (@(posedge clk) disable iff (rst)
        (!lvl_q && raw) |=> !act.b);

    // R5: a reversal during a running count restarts the wait
    p_retoggle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!settled && flip && use_dt) |=> (!act.a && !act.b));

    // R6: zero length or disabled gives an immediate complementary pair
    p_zero_len_r6: assert property (@(posedge clk) disable iff (rst)
        (flip && !use_dt) |=> (act.a != act.b));

endmodule

// File: rtl/pwm_route.sv
module pwm_route
    import pwm_out_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     act_a,
    input  logic [NUM_CH-1:0]     act_b,
    input  logic                  cp_en,
    input  logic [2*NUM_CH-1:0]   cp_pat,
    input  logic [NUM_CH-1:0]     pol_inv,
    output logic [NUM_CH-1:0]     out_a,
    output logic [NUM_CH-1:0]     out_b
);

    logic [NUM_CH-1:0] nxt_a;
    logic [NUM_CH-1:0] nxt_b;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            nxt_a[c] = to_level(resolve(pick_src(cp_en, cp_pat[2*c]),   act_a[c], act_a[0]), pol_inv[c]);
            nxt_b[c] = to_level(resolve(pick_src(cp_en, cp_pat[2*c+1]), act_b[c], act_a[0]), pol_inv[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_a <= '0;
            out_b <= '1;
        end else begin
            out_a <= nxt_a;
            out_b <= nxt_b;
        end
    end

    // R1: reset state of the pins
    p_reset_pins_r1: assert property (@(posedge clk)
        rst |=> (out_a == '0 && out_b == '1));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R2: without override and inversion both pins are never high together
        p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
            (!$past(cp_en) && !$past(pol_inv[c])) |-> !(out_a[c] && out_b[c]));
        // R8: a cleared pattern bit drives the passive level of the leg
        p_force_a_r8: assert property (@(posedge clk) disable iff (rst)
            (cp_en && !cp_pat[2*c]) |=> (out_a[c] == $past(pol_inv[c])));
        p_force_b_r8: assert property (@(posedge clk) disable iff (rst)
            (cp_en && !cp_pat[2*c+1]) |=> (out_b[c] == $past(pol_inv[c])));
    end

endmodule

// File: rtl/pwm_gate_stage.sv
module pwm_gate_stage
    import pwm_out_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int DT_W   = DEF_DT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        raw_pwm,
    input  logic [NUM_CH-1:0]        dt_en,
    input  logic [NUM_CH*DT_W-1:0]   dt_len,
    input  logic [NUM_CH-1:0]        pol_inv,
    input  logic                     cp_en,
    input  logic [2*NUM_CH-1:0]      cp_pat,
    output logic [NUM_CH-1:0]        out_a,
    output logic [NUM_CH-1:0]        out_b
);

    localparam int PAT_W = 2 * NUM_CH;

    logic [NUM_CH-1:0] act_a;
    logic [NUM_CH-1:0] act_b;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_leg
        gate_pair_t pair;

        pwm_deadtime #(
            .DT_W (DT_W)
        ) u_dt (
            .clk    (clk),
            .rst    (rst),
            .raw    (raw_pwm[c]),
            .dt_on  (dt_en[c]),
            .dt_len (dt_len[c*DT_W +: DT_W]),
            .act    (pair)
        );

        assign act_a[c] = pair.a;
        assign act_b[c] = pair.b;
    end

    pwm_route #(
        .NUM_CH (NUM_CH)
    ) u_route (
        .clk     (clk),
        .rst     (rst),
        .act_a   (act_a),
        .act_b   (act_b),
        .cp_en   (cp_en),
        .cp_pat  (cp_pat[PAT_W-1:0]),
        .pol_inv (pol_inv),
        .out_a   (out_a),
        .out_b   (out_b)
    );

endmodule

// File: tb/sim_pwm_gate_stage.sv
module sim_pwm_gate_stage;

    localparam int NCH     = 3;
    localparam int DTW     = 10;
    localparam int AGE_MAX = 100000;

    logic               clk = 1'b0;
    logic               rst;
    logic [NCH-1:0]     raw_pwm;
    logic [NCH-1:0]     dt_en;
    logic [NCH*DTW-1:0] dt_len;
    logic [NCH-1:0]     pol_inv;
    logic               cp_en;
    logic [2*NCH-1:0]   cp_pat;
    logic [NCH-1:0]     out_a;
    logic [NCH-1:0]     out_b;

    always #5 clk = ~clk;

    pwm_gate_stage #(.NUM_CH(NCH), .DT_W(DTW)) u0 (
        .clk(clk), .rst(rst), .raw_pwm(raw_pwm), .dt_en(dt_en), .dt_len(dt_len),
        .pol_inv(pol_inv), .cp_en(cp_en), .cp_pat(cp_pat), .out_a(out_a), .out_b(out_b)
    );

    int     n_cmp = 0;
    int     n_bad = 0;
    string  tag   = "R1";
    bit     started = 0;
    bit     done    = 0;

    // behavioural model: level and cycles since the last raw change
    bit             lvl [NCH];
    int             age [NCH];
    logic [NCH-1:0] exp_a;
    logic [NCH-1:0] exp_b;

    function automatic int wait_len(input int c);
        return dt_en[c] ? int'(dt_len[c*DTW +: DTW]) : 0;
    endfunction

    function automatic logic pin_from(input logic ovr, input logic patb, input logic own,
                                      input logic leg0, input logic inv);
        logic act;
        act = ovr ? (patb & leg0) : own;
        return act ^ inv;
    endfunction

    always @(posedge clk) begin
        logic [NCH-1:0] ia;
        logic [NCH-1:0] ib;
        if (rst) begin
            exp_a = '0;
            exp_b = '1;
            for (int c = 0; c < NCH; c++) begin
                lvl[c] = 1'b0;
                age[c] = AGE_MAX;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                ia[c] = lvl[c] && (age[c] >= wait_len(c));
                ib[c] = !lvl[c] && (age[c] >= wait_len(c));
            end
            for (int c = 0; c < NCH; c++) begin
                exp_a[c] = pin_from(cp_en, cp_pat[2*c],   ia[c], ia[0], pol_inv[c]);
                exp_b[c] = pin_from(cp_en, cp_pat[2*c+1], ib[c], ia[0], pol_inv[c]);
            end
            for (int c = 0; c < NCH; c++) begin
                if (raw_pwm[c] != lvl[c]) begin
                    lvl[c] = raw_pwm[c];
                    age[c] = 0;
                end else if (age[c] < AGE_MAX) begin
                    age[c] = age[c] + 1;
                end
            end
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            n_cmp++;
            if (out_a !== exp_a || out_b !== exp_b) begin
                n_bad++;
                $display("FAIL %s: out_a=%b out_b=%b expected out_a=%b out_b=%b",
                         tag, out_a, out_b, exp_a, exp_b);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // change dead-time setup only once every leg has settled
    task automatic set_dt(input logic [NCH-1:0] en, input int l0, input int l1, input int l2);
        step(70);
        dt_en  = en;
        dt_len = {DTW'(l2), DTW'(l1), DTW'(l0)};
        step(2);
    endtask

    task automatic run_raw(input int cycles, input int k);
        for (int i = 0; i < cycles; i++) begin
            for (int c = 0; c < NCH; c++)
                if ($urandom_range(k - 1) == 0) raw_pwm[c] = ~raw_pwm[c];
            step(1);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; raw_pwm = '0; dt_en = '0; dt_len = '0;
        pol_inv = '1; cp_en = 1'b1; cp_pat = '1;
        tag = "R1";
        step(4);
        // R1: reset level must not depend on polarity or override inputs
        pol_inv = '0; cp_en = 1'b0; cp_pat = '0;
        step(2);
        rst = 1'b0;
        step(5);

        tag = "R2";
        run_raw(200, 2);

        tag = "R3";
        set_dt(3'b111, 5, 9, 13);
        run_raw(300, 25);
        raw_pwm = '1; step(20); raw_pwm = '0; step(20);

        tag = "R5";
        set_dt(3'b111, 10, 10, 10);
        run_raw(300, 3);

        tag = "R6";
        set_dt(3'b111, 0, 0, 0);
        run_raw(200, 2);

        tag = "R7";
        set_dt(3'b101, 4, 7, 3);
        for (int j = 0; j < 10; j++) begin
            pol_inv = NCH'($urandom);
            run_raw(30, 6);
        end

        tag = "R8";
        cp_en = 1'b1;
        set_dt(3'b011, 6, 2, 0);
        for (int j = 0; j < 30; j++) begin
            cp_pat  = (2*NCH)'($urandom);
            pol_inv = NCH'($urandom);
            run_raw(15, 4);
        end
        cp_en = 1'b0;

        tag = "R4";
        for (int j = 0; j < 20; j++) begin
            set_dt(NCH'($urandom), $urandom_range(63), $urandom_range(63), $urandom_range(63));
            cp_en   = ($urandom_range(3) == 0);
            cp_pat  = (2*NCH)'($urandom);
            pol_inv = NCH'($urandom);
            run_raw(100, $urandom_range(2, 30));
        end

        tag = "R1";
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(3);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL %s: watchdog expired, actual=running expected=finished", tag);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule